// File: doc/BRIEF.md
# SDRAM Single-Access Command Sequencer

This block carries out one SDRAM read or one SDRAM write for each accepted request. It issues the whole command sequence on the active-low chip-select, row-strobe, column-strobe and write-enable pins. First it closes the target bank with a precharge. Then it opens the requested row. Last it issues the column command. Each command carries its own bank, row or column address. Every other cycle carries a no-operation command.

The lengths of the three phases are set at run time through configuration inputs:

- the precharge phase,
- the spacing from row open to the column command,
- the column phase of a read, which also fixes when the read word is sampled.

Two optional trailing cycles can be added on request. One is a clock-suspend cycle, in which the clock-enable pin is held low. The other is a write-recovery cycle, added after a write before the block reports completion.

The block accepts a request only while idle and samples the configuration at that moment. It returns read data with a one-cycle valid strobe and marks the end of every access with a one-cycle completion pulse. All pin outputs come straight from registers.

Top module: `sdram_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, the pins carry the no-operation code, clock enable is high, the data bus is not driven, and busy, done and rd_valid are low.
- R2: Commands are coded as {cs_n,ras_n,cas_n,we_n}: close-bank 0010, open-row 0011, read 0101, write 0100, no-operation 0111. Every cycle of an access that is not one of its three command cycles carries no-operation.
- R3: A request is taken on a clock edge at which the block is idle and req_valid is high. The close-bank command appears in the cycle after that edge (cycle 1). The phase lasts cfg_pre_len+1 cycles (P, field values 0..3).
- R4: The open-row command appears in cycle P+1. It carries sd_ba = req_addr[ADDR_W-1 -: BA_W] and sd_addr = req_addr[COL_W +: ROW_W]. The phase lasts cfg_rcd_len+1 cycles (R).
- R5: The read command appears in cycle P+R+1 with sd_addr = req_addr[COL_W-1:0], zero-extended. The read column phase lasts C cycles: 2 for cfg_col_len 0, 3 for 1, and 4 for 2 or 3.
- R6: For a read, sd_dq_in is sampled at the clock edge that ends cycle P+R+C. It appears on rd_data with rd_valid high for exactly the following cycle. rd_valid is low at all other times.
- R7: The write command appears in cycle P+R+1 with the column address. Its column phase is one cycle (C=1). sd_dq_oe is high and sd_dq_out equals req_wdata in that cycle only.
- R8: When cfg_susp_en is set, cycle P+R+C+1 has sd_cke low and no-operation. sd_cke is high in every other cycle.
- R9: When cfg_wrec_en is set and the access is a write, one more no-operation cycle follows the suspend cycle, if there is one. For a read, cfg_wrec_en has no effect.
- R10: done is high for exactly cycle D = P+R+C+S+W+1, where S and W are 1 when the respective trailing cycle is present. busy is high in cycles 1 to D-1 and low in cycle D.
- R11: req_valid and configuration changes while busy are ignored. The access keeps the addresses and lengths sampled when it was taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken while idle |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_addr | input | ADDR_W | {bank, row, column} |
| req_wdata | input | DATA_W | Write word |
| cfg_pre_len | input | 2 | Close-bank phase length minus one |
| cfg_rcd_len | input | 2 | Row-to-column spacing minus one |
| cfg_col_len | input | 2 | Read column phase selector |
| cfg_susp_en | input | 1 | Insert clock-suspend cycle |
| cfg_wrec_en | input | 1 | Insert write-recovery cycle on writes |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Captured read word |
| rd_valid | output | 1 | One-cycle read data strobe |
| sd_cke | output | 1 | Clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BA_W | Bank address |
| sd_addr | output | ROW_W | Row or column address |
| sd_dq_out | output | DATA_W | Write data to memory |
| sd_dq_oe | output | 1 | Data bus drive enable |
| sd_dq_in | input | DATA_W | Read data from memory |

## Verification
Reads are run with the three length fields at their minimum, at their maximum and at mixed values, so that an error in any one field moves a command or the done pulse by a cycle. The memory data input changes value every cycle, so the captured word shows exactly which edge sampled it. Writes are run with neither trailing cycle, with write recovery alone, and with both trailing cycles, which tells the two trailing cycles apart in position and count. A read with write recovery enabled shows that the option is ignored for reads. A read with a new request and new configuration applied mid-access shows that both are ignored once an access has been taken.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_RD  = 4'b0101,
    CMD_WR  = 4'b0100,
    CMD_NOP = 4'b0111
  } sd_cmd_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PRE,
    PH_ROW,
    PH_COL,
    PH_SUSP,
    PH_WREC
  } phase_e;

  typedef struct packed {
    logic [1:0] pre;
    logic [1:0] rcd;
    logic [1:0] col;
    logic       susp;
    logic       wrec;
  } cfg_t;

  localparam int TMR_W = 2;

  // read column phase: 0 -> 2 cycles, 1 -> 3, 2/3 -> 4; returns length minus one
  function automatic logic [TMR_W-1:0] col_load(input logic [1:0] f);
    return (f >= 2'd2) ? 2'd3 : f + 2'd1;
  endfunction

endpackage

// File: rtl/sdram_seq_timer.sv
module sdram_seq_timer #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         last
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign last = (cnt == '0);

endmodule

// File: rtl/sdram_seq_pins.sv
module sdram_seq_pins
  import sdram_seq_pkg::*;
#(
  parameter int BA_W   = 2,
  parameter int ROW_W  = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  sd_cmd_e           cmd_nxt,
  input  logic [BA_W-1:0]   ba_nxt,
  input  logic [ROW_W-1:0]  addr_nxt,
  input  logic              cke_nxt,
  input  logic              oe_nxt,
  input  logic [DATA_W-1:0] dq_nxt,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic              sd_cke,
  output logic [BA_W-1:0]   sd_ba,
  output logic [ROW_W-1:0]  sd_addr,
  output logic              sd_dq_oe,
  output logic [DATA_W-1:0] sd_dq_out
);

  always_ff @(posedge clk) begin
    if (rst) begin
      {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} <= CMD_NOP;
      sd_cke    <= 1'b1;
      sd_ba     <= '0;
      sd_addr   <= '0;
      sd_dq_oe  <= 1'b0;
      sd_dq_out <= '0;
    end else begin
      {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} <= cmd_nxt;
      sd_cke    <= cke_nxt;
      sd_ba     <= ba_nxt;
      sd_addr   <= addr_nxt;
      sd_dq_oe  <= oe_nxt;
      sd_dq_out <= dq_nxt;
    end
  end

endmodule

// File: rtl/sdram_seq_rdcap.sv
module sdram_seq_rdcap #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= cap;
      if (cap) rd_data <= dq_in;
    end
  end

endmodule

// File: rtl/sdram_seq.sv
module sdram_seq
  import sdram_seq_pkg::*;
#(
  parameter int BA_W   = 2,
  parameter int ROW_W  = 12,
  parameter int COL_W  = 9,
  parameter int DATA_W = 16,
  localparam int ADDR_W = BA_W + ROW_W + COL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        cfg_pre_len,
  input  logic [1:0]        cfg_rcd_len,
  input  logic [1:0]        cfg_col_len,
  input  logic              cfg_susp_en,
  input  logic              cfg_wrec_en,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BA_W-1:0]   sd_ba,
  output logic [ROW_W-1:0]  sd_addr,
  output logic [DATA_W-1:0] sd_dq_out,
  output logic              sd_dq_oe,
  input  logic [DATA_W-1:0] sd_dq_in
);

  phase_e ph, ph_nxt;

  // access captured at acceptance
  logic              r_wr;
  logic [BA_W-1:0]   r_ba;
  logic [ROW_W-1:0]  r_row;
  logic [COL_W-1:0]  r_col;
  logic [DATA_W-1:0] r_wdata;
  cfg_t              r_cfg;

  logic              accept;
  logic              tmr_load;
  logic [TMR_W-1:0]  tmr_val;
  logic              tmr_last;
  logic              cap;
  logic              done_nxt;
  sd_cmd_e           cmd_nxt;
  logic [BA_W-1:0]   ba_nxt;
  logic [ROW_W-1:0]  addr_nxt;
  logic              cke_nxt;
  logic              oe_nxt;

  sdram_seq_timer #(.W(TMR_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .last     (tmr_last)
  );

  // trailing-cycle selection after the column phase and after suspend
  function automatic phase_e after_col(input cfg_t c, input logic wr);
    if (c.susp)          return PH_SUSP;
    else if (wr && c.wrec) return PH_WREC;
    else                 return PH_IDLE;
  endfunction

  always_comb begin
    ph_nxt   = ph;
    cmd_nxt  = CMD_NOP;
    ba_nxt   = r_ba;
    addr_nxt = r_row;
    cke_nxt  = 1'b1;
    oe_nxt   = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    cap      = 1'b0;
    done_nxt = 1'b0;
    accept   = 1'b0;
    unique case (ph)
      PH_IDLE: begin
        if (req_valid) begin
          accept   = 1'b1;
          ph_nxt   = PH_PRE;
          cmd_nxt  = CMD_PRE;
          ba_nxt   = req_addr[ADDR_W-1 -: BA_W];
          tmr_load = 1'b1;
          tmr_val  = cfg_pre_len;
        end
      end
      PH_PRE: begin
        if (tmr_last) begin
          ph_nxt   = PH_ROW;
          cmd_nxt  = CMD_ACT;
          tmr_load = 1'b1;
          tmr_val  = r_cfg.rcd;
        end
      end
      PH_ROW: begin
        if (tmr_last) begin
          ph_nxt   = PH_COL;
          cmd_nxt  = r_wr ? CMD_WR : CMD_RD;
          addr_nxt = ROW_W'(r_col);
          oe_nxt   = r_wr;
          tmr_load = 1'b1;
          tmr_val  = r_wr ? '0 : col_load(r_cfg.col);
        end
      end
      PH_COL: begin
        if (tmr_last) begin
          cap    = !r_wr;
          ph_nxt = after_col(r_cfg, r_wr);
          if (ph_nxt == PH_SUSP) cke_nxt = 1'b0;
          if (ph_nxt == PH_IDLE) done_nxt = 1'b1;
        end
      end
      PH_SUSP: begin
        if (r_wr && r_cfg.wrec) begin
          ph_nxt = PH_WREC;
        end else begin
          ph_nxt   = PH_IDLE;
          done_nxt = 1'b1;
        end
      end
      PH_WREC: begin
        ph_nxt   = PH_IDLE;
        done_nxt = 1'b1;
      end
      default: ph_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph      <= PH_IDLE;
      done    <= 1'b0;
      r_wr    <= 1'b0;
      r_ba    <= '0;
      r_row   <= '0;
      r_col   <= '0;
      r_wdata <= '0;
      r_cfg   <= '0;
    end else begin
      ph   <= ph_nxt;
      done <= done_nxt;
      if (accept) begin
        r_wr    <= req_write;
        r_ba    <= req_addr[ADDR_W-1 -: BA_W];
        r_row   <= req_addr[COL_W +: ROW_W];
        r_col   <= req_addr[COL_W-1:0];
        r_wdata <= req_wdata;
        r_cfg   <= '{pre: cfg_pre_len, rcd: cfg_rcd_len, col: cfg_col_len,
                     susp: cfg_susp_en, wrec: cfg_wrec_en};
      end
    end
  end

  assign busy = (ph != PH_IDLE);

  sdram_seq_pins #(.BA_W(BA_W), .ROW_W(ROW_W), .DATA_W(DATA_W)) u_pins (
    .clk       (clk),
    .rst       (rst),
    .cmd_nxt   (cmd_nxt),
    .ba_nxt    (ba_nxt),
    .addr_nxt  (addr_nxt),
    .cke_nxt   (cke_nxt),
    .oe_nxt    (oe_nxt),
    .dq_nxt    (r_wdata),
    .sd_cs_n   (sd_cs_n),
    .sd_ras_n  (sd_ras_n),
    .sd_cas_n  (sd_cas_n),
    .sd_we_n   (sd_we_n),
    .sd_cke    (sd_cke),
    .sd_ba     (sd_ba),
    .sd_addr   (sd_addr),
    .sd_dq_oe  (sd_dq_oe),
    .sd_dq_out (sd_dq_out)
  );

  sdram_seq_rdcap #(.DATA_W(DATA_W)) u_rdcap (
    .clk      (clk),
    .rst      (rst),
    .cap      (cap),
    .dq_in    (sd_dq_in),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

endmodule

// File: rtl/sdram_seq_chk.sv
module sdram_seq_chk (
  input logic clk,
  input logic rst,
  input logic sd_cs_n,
  input logic sd_ras_n,
  input logic sd_cas_n,
  input logic sd_we_n,
  input logic sd_cke,
  input logic sd_dq_oe,
  input logic busy,
  input logic done,
  input logic rd_valid
);

  logic [3:0] cmd;
  assign cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  // R2: only the five legal codes appear
  assert_legal_cmd_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd == 4'b0010 || cmd == 4'b0011 || cmd == 4'b0101 ||
     cmd == 4'b0100 || cmd == 4'b0111));

  // R3: close-bank only opens an access that was just taken
  assert_pre_start_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd == 4'b0010) |-> (busy && !$past(busy)));

  // R4: open-row only inside an access
  assert_act_busy_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd == 4'b0011) |-> busy);

  // R6: read strobe lasts one cycle
  assert_rd_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);

  // R7: bus driven exactly with the write command
  assert_wr_oe_R7: assert property (@(posedge clk) disable iff (rst)
    sd_dq_oe == (cmd == 4'b0100));

  // R8: suspend cycle carries no-operation and lasts one cycle
  assert_susp_nop_R8: assert property (@(posedge clk) disable iff (rst)
    !sd_cke |-> (cmd == 4'b0111 && busy));
  assert_susp_one_R8: assert property (@(posedge clk) disable iff (rst)
    !sd_cke |=> sd_cke);

  // R10: completion pulse ends the busy window
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_busy_end_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

endmodule

bind sdram_seq sdram_seq_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .sd_cs_n  (sd_cs_n),
  .sd_ras_n (sd_ras_n),
  .sd_cas_n (sd_cas_n),
  .sd_we_n  (sd_we_n),
  .sd_cke   (sd_cke),
  .sd_dq_oe (sd_dq_oe),
  .busy     (busy),
  .done     (done),
  .rd_valid (rd_valid)
);

// File: tb/sdram_seq_test.sv
`timescale 1ns/1ps
module sdram_seq_test;

  localparam int BA_W   = 2;
  localparam int ROW_W  = 12;
  localparam int COL_W  = 9;
  localparam int DATA_W = 16;
  localparam int ADDR_W = BA_W + ROW_W + COL_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic              req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic [1:0]        cfg_pre_len = '0;
  logic [1:0]        cfg_rcd_len = '0;
  logic [1:0]        cfg_col_len = '0;
  logic              cfg_susp_en = 1'b0;
  logic              cfg_wrec_en = 1'b0;
  logic              busy, done, rd_valid, sd_cke;
  logic              sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
  logic [DATA_W-1:0] rd_data, sd_dq_out;
  logic [DATA_W-1:0] sd_dq_in = '0;
  logic [BA_W-1:0]   sd_ba;
  logic [ROW_W-1:0]  sd_addr;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  sdram_seq #(.BA_W(BA_W), .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .cfg_pre_len(cfg_pre_len),
    .cfg_rcd_len(cfg_rcd_len), .cfg_col_len(cfg_col_len),
    .cfg_susp_en(cfg_susp_en), .cfg_wrec_en(cfg_wrec_en), .busy(busy),
    .done(done), .rd_data(rd_data), .rd_valid(rd_valid), .sd_cke(sd_cke),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr),
    .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in)
  );

  function automatic logic [3:0] cmd_now();
    return {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  endfunction

  function automatic logic [DATA_W-1:0] dq_pat(input int k);
    return DATA_W'(32'h5A00 + k * 37);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one access; checks every cycle against the timing in the requirements
  task automatic run_access(input bit wr, input logic [ADDR_W-1:0] a,
                            input logic [DATA_W-1:0] wd, input int pre,
                            input int rcd, input int cl, input bit su,
                            input bit wre, input bit disturb);
    int P = pre + 1;
    int R = rcd + 1;
    int C = wr ? 1 : 2 + ((cl > 2) ? 2 : cl);
    int S = su ? 1 : 0;
    int W = (wr && wre) ? 1 : 0;
    int D = P + R + C + S + W + 1;
    int K_COL = P + R + 1;
    int K_SUS = P + R + C + 1;
    int K_RDV = P + R + C + 1;
    int nop_bad = 0, cke_bad = 0, oe_bad = 0, busy_bad = 0, done_bad = 0, rdv_bad = 0;
    logic [BA_W-1:0]  e_ba  = a[ADDR_W-1 -: BA_W];
    logic [ROW_W-1:0] e_row = a[COL_W +: ROW_W];
    logic [ROW_W-1:0] e_col = ROW_W'(a[COL_W-1:0]);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
    cfg_pre_len = 2'(pre); cfg_rcd_len = 2'(rcd); cfg_col_len = 2'(cl);
    cfg_susp_en = su; cfg_wrec_en = wre;
    sd_dq_in = dq_pat(0);
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 1; k <= D + 1; k++) begin
      if (k == 1) begin
        check(cmd_now() == 4'b0010, "R3", "close-bank cycle 1", cmd_now(), 4'b0010);
        check(sd_ba == e_ba, "R3", "close-bank bank", sd_ba, e_ba);
      end else if (k == P + 1) begin
        check(cmd_now() == 4'b0011, "R4", "open-row cycle", cmd_now(), 4'b0011);
        check(sd_ba == e_ba, "R4", "open-row bank", sd_ba, e_ba);
        check(sd_addr == e_row, "R4", "open-row address", sd_addr, e_row);
      end else if (k == K_COL) begin
        if (wr) begin
          check(cmd_now() == 4'b0100, "R7", "write command cycle", cmd_now(), 4'b0100);
          check(sd_addr == e_col, "R7", "write column", sd_addr, e_col);
          check(sd_dq_oe == 1'b1, "R7", "write drive enable", sd_dq_oe, 1);
          check(sd_dq_out == wd, "R7", "write data", sd_dq_out, wd);
        end else begin
          check(cmd_now() == 4'b0101, "R5", "read command cycle", cmd_now(), 4'b0101);
          check(sd_addr == e_col, "R5", "read column", sd_addr, e_col);
        end
      end else if (cmd_now() != 4'b0111) begin
        nop_bad++;
        if (nop_bad == 1) $display("  note: cycle %0d code %b", k, cmd_now());
      end
      if (k != K_COL && sd_dq_oe) oe_bad++;
      if (su && k == K_SUS) check(sd_cke == 1'b0, "R8", "suspend cycle cke", sd_cke, 0);
      else if (!sd_cke) cke_bad++;
      if (k < D && (!busy || done)) busy_bad++;
      if (k == D) begin
        check(done == 1'b1, "R10", "done in final cycle", done, 1);
        check(busy == 1'b0, "R10", "busy low at done", busy, 0);
      end else if (done) done_bad++;
      if (!wr && k == K_RDV) begin
        check(rd_valid == 1'b1, "R6", "rd_valid cycle", rd_valid, 1);
        check(rd_data == dq_pat(P + R + C), "R6", "rd_data sample edge",
              rd_data, dq_pat(P + R + C));
      end else if (rd_valid) rdv_bad++;
      if (disturb) begin
        if (k == 2) begin
          req_valid = 1'b1; req_write = ~wr; req_addr = ~a;
          cfg_pre_len = 2'(pre + 1); cfg_rcd_len = 2'(rcd + 2);
          cfg_col_len = 2'(cl + 1); cfg_susp_en = ~su; cfg_wrec_en = ~wre;
        end
        if (k == 4) req_valid = 1'b0;
      end
      sd_dq_in = dq_pat(k);
      @(negedge clk);
    end
    check(nop_bad == 0, "R2", "no-operation elsewhere (bad cycles)", nop_bad, 0);
    check(oe_bad == 0, "R7", "drive enable outside write (bad cycles)", oe_bad, 0);
    check(cke_bad == 0, "R8", "cke high elsewhere (bad cycles)", cke_bad, 0);
    check(busy_bad == 0, "R10", "busy window (bad cycles)", busy_bad, 0);
    check(done_bad == 0, "R10", "done single cycle (bad cycles)", done_bad, 0);
    check(rdv_bad == 0, "R6", "rd_valid elsewhere (bad cycles)", rdv_bad, 0);
  endtask

  task automatic test_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(cmd_now() == 4'b0111, "R1", "reset code", cmd_now(), 4'b0111);
    check(sd_cke && !sd_dq_oe, "R1", "reset cke/oe", {sd_cke, sd_dq_oe}, 2'b10);
    check(!busy && !done && !rd_valid, "R1", "reset status", {busy, done, rd_valid}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(cmd_now() == 4'b0111 && !busy, "R1", "idle after reset", {cmd_now(), busy}, 5'b01110);
  endtask

  task automatic test_read_min();   // R3 R4 R5 R6 shortest lengths
    run_access(1'b0, 23'h4A_5123, '0, 0, 0, 0, 1'b0, 1'b0, 1'b0);
  endtask
  task automatic test_read_max();   // R5: field 3 behaves as 4 cycles
    run_access(1'b0, 23'h7F_FFFF, '0, 3, 3, 3, 1'b0, 1'b0, 1'b0);
  endtask
  task automatic test_read_mixed(); // R3 R4 R5 distinct fields
    run_access(1'b0, 23'h15_0A0F, '0, 1, 2, 1, 1'b0, 1'b0, 1'b0);
  endtask
  task automatic test_read_susp();  // R8 with column field 2
    run_access(1'b0, 23'h33_3333, '0, 2, 0, 2, 1'b1, 1'b0, 1'b0);
  endtask
  task automatic test_read_wrec();  // R9: recovery ignored on reads
    run_access(1'b0, 23'h02_8001, '0, 0, 1, 0, 1'b0, 1'b1, 1'b0);
  endtask
  task automatic test_write_plain(); // R7
    run_access(1'b1, 23'h6C_1E5A, 16'hBEEF, 0, 0, 3, 1'b0, 1'b0, 1'b0);
  endtask
  task automatic test_write_wrec(); // R9
    run_access(1'b1, 23'h11_22F3, 16'h1234, 2, 1, 0, 1'b0, 1'b1, 1'b0);
  endtask
  task automatic test_write_both(); // R8 R9 order
    run_access(1'b1, 23'h55_0155, 16'hA5C3, 3, 0, 0, 1'b1, 1'b1, 1'b0);
  endtask
  task automatic test_busy_ignore(); // R11
    run_access(1'b0, 23'h2B_4C5D, '0, 2, 1, 1, 1'b0, 1'b0, 1'b1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R10 watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    test_reset();
    test_read_min();
    test_read_max();
    test_read_mixed();
    test_read_susp();
    test_read_wrec();
    test_write_plain();
    test_write_wrec();
    test_write_both();
    test_busy_ignore();
    test_read_mixed();
    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule